// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address by fetching descriptors from a two-level translation table in memory. A requester presents an address on a valid/ready lookup port. The walker reads one first-level descriptor, and when that descriptor points to a second-level table it reads one second-level descriptor as well. It then returns the physical address and the size of the mapping that matched. If no mapping matched, it returns a fault that names the faulting level.

Three mapping sizes can exist side by side. A first-level descriptor can map a 1MB section directly. A second-level descriptor can map a 64KB large page or a 4KB small page. A large page is stored in the table as 16 identical neighbouring entries, so the walker needs no special handling for it: any one of those entries decodes the same way.

The walker handles one lookup at a time and has at most one memory read in flight. The memory port carries a request address with a valid/ready handshake. Read data comes back later as a one-cycle valid pulse.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are both 0.
- R2: The first descriptor read goes to address `l1_base + va[31:20]*4`, using the `l1_base` value sampled when the lookup is accepted.
- R3: A first-level descriptor whose bits [1:0] are 00 or 11 gives a response with `rsp_fault`=1, `rsp_level`=0, `rsp_pa`=0 and `rsp_size`=0. No second read is issued. `rsp_va` carries the looked-up address.
- R4: A first-level descriptor with bits [1:0]=10 gives `rsp_pa = {desc[31:20], va[19:0]}` with `rsp_size`=3 (1MB). No second read is issued.
- R5: A first-level descriptor with bits [1:0]=01 causes a second read at `{desc[31:10], va[19:12], 2'b00}`.
- R6: A second-level descriptor with bits [1:0]=00 gives a response with `rsp_fault`=1, `rsp_level`=1, `rsp_pa`=0 and `rsp_size`=0.
- R7: A second-level descriptor with bits [1:0]=01 gives `rsp_pa = {desc[31:16], va[15:0]}` with `rsp_size`=2 (64KB).
- R8: A second-level descriptor with bit 1 set gives `rsp_pa = {desc[31:12], va[11:0]}` with `rsp_size`=1 (4KB).
- R9: A memory request stays asserted with a stable address until it is accepted. No further request is raised until read data for the accepted one has returned.
- R10: A lookup is accepted only while idle. `req_ready` stays 0 from acceptance until the response is taken. The response stays valid and stable until `rsp_ready` is 1, and the block is idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| l1_base | input | 32 | Base address of the first-level table |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Walker idle and able to accept a lookup |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | 32 | Physical address (0 on a fault) |
| rsp_size | output | 2 | 0 none, 1 4KB, 2 64KB, 3 1MB |
| rsp_fault | output | 1 | No valid mapping was found |
| rsp_level | output | 1 | Faulting level: 0 first, 1 second |
| rsp_va | output | 32 | Virtual address of the lookup |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Word address of the descriptor |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 32 | Descriptor word |

## Verification
The bench targets the corner cases of descriptor decoding:
- The 11 first-level code must fault. A walker that treated it like 01 would issue a stray second read.
- The 11 second-level code must decode as a small page. A walker that tested both low bits would report it as a large page or a fault.
- A section descriptor must not be followed by a second read. A walker that walked on would hang waiting for data or corrupt the next lookup.

The bench also stalls both the memory request and the response to catch addresses or results that drift while held. It uses all-ones addresses and a table base near the top of memory to catch index fields shifted by a bit or truncated offsets.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] l1_base,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_va,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [AW-1:0] rsp_pa,
  output logic [1:0]    rsp_size,
  output logic          rsp_fault,
  output logic          rsp_level,
  output logic [AW-1:0] rsp_va,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data
);
  localparam logic [1:0] SZ_NONE = 2'd0, SZ_SMALL = 2'd1, SZ_LARGE = 2'd2, SZ_SECT = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_L1_REQ, S_L1_WAIT, S_L2_REQ, S_L2_WAIT, S_RESP} st_t;

  st_t         st;
  logic [31:0] va_q, base_q, pa_q;
  logic [21:0] l2ptr_q;
  logic [1:0]  size_q;
  logic        fault_q, level_q;
  logic [31:0] d;

  assign d             = mem_rsp_data;
  assign req_ready     = (st == S_IDLE);
  assign rsp_valid     = (st == S_RESP);
  assign mem_req_valid = (st == S_L1_REQ) || (st == S_L2_REQ);
  assign mem_req_addr  = (st == S_L2_REQ) ? {l2ptr_q, va_q[19:12], 2'b00}
                                          : base_q + {18'd0, va_q[31:20], 2'b00};
  assign rsp_pa        = pa_q;
  assign rsp_size      = size_q;
  assign rsp_fault     = fault_q;
  assign rsp_level     = level_q;
  assign rsp_va        = va_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      l2ptr_q <= '0;
      size_q  <= SZ_NONE;
      fault_q <= 1'b0;
      level_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_va;
          base_q  <= l1_base;
          pa_q    <= '0;
          size_q  <= SZ_NONE;
          fault_q <= 1'b0;
          level_q <= 1'b0;
          st      <= S_L1_REQ;
        end
        S_L1_REQ: if (mem_req_ready) st <= S_L1_WAIT;
        S_L1_WAIT: if (mem_rsp_valid) begin
          case (d[1:0])
            2'b10: begin
              pa_q   <= {d[31:20], va_q[19:0]};
              size_q <= SZ_SECT;
              st     <= S_RESP;
            end
            2'b01: begin
              l2ptr_q <= d[31:10];
              st      <= S_L2_REQ;
            end
            default: begin
              fault_q <= 1'b1;
              level_q <= 1'b0;
              st      <= S_RESP;
            end
          endcase
        end
        S_L2_REQ: if (mem_req_ready) st <= S_L2_WAIT;
        S_L2_WAIT: if (mem_rsp_valid) begin
          if (d[1]) begin
            pa_q   <= {d[31:12], va_q[11:0]};
            size_q <= SZ_SMALL;
          end else if (d[0]) begin
            pa_q   <= {d[31:16], va_q[15:0]};
            size_q <= SZ_LARGE;
          end else begin
            fault_q <= 1'b1;
            level_q <= 1'b1;
          end
          st <= S_RESP;
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_pa,
  input logic [1:0]  rsp_size,
  input logic        rsp_fault,
  input logic        rsp_level,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R9
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid); // R9
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R10
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pa) && $stable(rsp_size) && $stable(rsp_fault) && $stable(rsp_level)); // R10
  AST_RSP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> req_ready); // R10
  AST_FAULT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_pa == 32'd0 && rsp_size == 2'd0); // R3
  AST_MAP_SIZED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_size != 2'd0); // R4
  AST_QUIET_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !mem_req_valid && !req_ready); // R10
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, req_valid, req_ready, rsp_valid, rsp_ready, rsp_fault, rsp_level;
  logic        mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [31:0] l1_base, req_va, rsp_pa, rsp_va, mem_req_addr, mem_rsp_data;
  logic [1:0]  rsp_size;

  ptw_walker dut (.*);

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  task automatic lookup(input logic [31:0] base, input logic [31:0] va,
                        input logic [31:0] d1, input logic [31:0] d2);
    logic [31:0] a1, a2, e_pa, hold_pa;
    logic [1:0]  e_sz;
    logic        e_f, e_l;
    int          nf;
    string       tg;
    a1 = base + {18'd0, va[31:20], 2'b00};
    a2 = {d1[31:10], va[19:12], 2'b00};
    e_pa = 0; e_sz = 0; e_f = 0; e_l = 0; nf = 1;
    if (d1[1:0] == 2'b10) begin
      e_pa = {d1[31:20], va[19:0]}; e_sz = 3; tg = "R4";
    end else if (d1[1:0] == 2'b01) begin
      nf = 2;
      if (d2[1]) begin e_pa = {d2[31:12], va[11:0]}; e_sz = 1; tg = "R8"; end
      else if (d2[0]) begin e_pa = {d2[31:16], va[15:0]}; e_sz = 2; tg = "R7"; end
      else begin e_f = 1; e_l = 1; tg = "R6"; end
    end else begin
      e_f = 1; tg = "R3";
    end

    @(negedge clk);
    l1_base = base; req_va = va; req_valid = 1;
    chk("R10", "idle ready", {31'd0, req_ready}, 1);
    @(negedge clk);
    req_valid = 0; l1_base = $urandom; req_va = $urandom;
    chk("R10", "busy ready", {31'd0, req_ready}, 0);

    for (int k = 0; k < nf; k++) begin
      bit got = 0, seen = 0;
      int guard = 0;
      while (!got && guard < 50) begin
        bit v;
        v = mem_req_valid;
        if (v && !seen) begin
          seen = 1;
          if (k == 0) chk("R2", "l1 addr", mem_req_addr, a1);
          else        chk("R5", "l2 addr", mem_req_addr, a2);
        end
        mem_req_ready = $urandom % 2;
        @(negedge clk);
        if (v && mem_req_ready) got = 1;
        guard++;
      end
      mem_req_ready = 0;
      repeat ($urandom % 3) begin
        chk("R9", "no req while pending", {31'd0, mem_req_valid}, 0);
        @(negedge clk);
      end
      mem_rsp_valid = 1; mem_rsp_data = (k == 0) ? d1 : d2;
      chk("R9", "no req at data", {31'd0, mem_req_valid}, 0);
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_data = $urandom;
    end

    chk(tg, "rsp_valid", {31'd0, rsp_valid}, 1);
    chk(tg, "no extra read", {31'd0, mem_req_valid}, 0);
    chk(tg, "pa", rsp_pa, e_pa);
    chk(tg, "size", {30'd0, rsp_size}, {30'd0, e_sz});
    chk(tg, "fault", {31'd0, rsp_fault}, {31'd0, e_f});
    if (e_f) begin
      chk(tg, "level", {31'd0, rsp_level}, {31'd0, e_l});
      chk(tg, "fault va", rsp_va, va);
    end
    hold_pa = rsp_pa;
    repeat ($urandom % 3) begin
      rsp_ready = 0;
      @(negedge clk);
      chk("R10", "rsp held", {31'd0, rsp_valid}, 1);
      chk("R10", "pa stable", rsp_pa, hold_pa);
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk("R10", "rsp dropped", {31'd0, rsp_valid}, 0);
    chk("R10", "idle again", {31'd0, req_ready}, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 0; req_valid = 0; rsp_ready = 0; mem_req_ready = 0; mem_rsp_valid = 0;
    l1_base = 0; req_va = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "req_ready", {31'd0, req_ready}, 1);
    chk("R1", "rsp_valid", {31'd0, rsp_valid}, 0);
    chk("R1", "mem_req_valid", {31'd0, mem_req_valid}, 0);

    lookup(32'h8000_4000, 32'hFFFF_FFFF, 32'h1230_0002, 32'h0);
    lookup(32'hFFFF_C000, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0);
    lookup(32'h0000_0004, 32'h0010_0000, 32'hABCD_E003, 32'h0);
    lookup(32'h4000_0000, 32'hFFFF_FFFF, 32'hFFFF_FC01, 32'hFFFF_F003);
    lookup(32'h4000_0000, 32'h0000_0000, 32'h1234_5401, 32'h0000_0000);
    lookup(32'h4000_0000, 32'h89AB_CDEF, 32'h1234_5401, 32'h5555_0001);
    lookup(32'h4000_0000, 32'h89AB_CDEF, 32'h1234_5401, 32'h7777_7002);
    lookup(32'h4000_0000, 32'h89AB_CDEF, 32'h1234_5401, 32'hFFFF_FFFC);

    for (int i = 0; i < 400; i++) begin
      logic [31:0] d1, d2;
      d1 = $urandom; d2 = $urandom;
      if (($urandom % 4) != 0) d1[1:0] = 2'b01;
      lookup($urandom, $urandom, d1, d2);
    end
    finish_run();
  end
endmodule